// File: doc/BRIEF.md
# Segmented Host Cycle Controller

This block sits between a 16-bit host bus and the wide registers of a search engine. When the active-low enable falls, the block starts a bus cycle. At that moment it latches two active-low control inputs, which pick one of four cycle types. A data write sends one 16-bit slice of a 64-bit destination register out on a write strobe, together with a segment index. A data read asks for one slice of the source register and puts the returned value on the bus. A command read returns a status word. A command write runs a small command set: select the destination, select the source, load the control word, load the segment-control word, or soft reset.

A wide value moves in one to four bus cycles. Two independent segment counters handle this, one for the destination and one for the source. Each counter runs from its start count to its end count and then wraps back to its start count. A data write that lands on the destination end count fires a compare strobe, provided the destination is the comparand or one of the two masks. Loading the control word also fires a compare strobe, so the new settings take effect. A soft reset does not fire one.

Top module: `host_seg_ctrl`

## Requirements
- R1: A cycle with {w_n,cm_n}=01 is a data write. One clock after the enable falls, `wr_stb` pulses for one clock, and `wr_data` holds the bus value captured at the fall.
- R2: A cycle with {w_n,cm_n}=11 is a data read. `rd_stb` pulses for one clock. From then until the enable rises, `dq_oe` is high and `dq_out` equals `rd_data`.
- R3: A cycle with {w_n,cm_n}=10 is a command read. It drives `dq_oe`, and `dq_out` carries `match_in` in bit 0, `full_in` in bit 1 and zero in every other bit. It gives no read or write strobe.
- R4: A cycle with {w_n,cm_n}=00 is a command write, with the opcode in bus bits 15:12:
  - 1 sets the destination to bits 1:0.
  - 2 sets the source to bits 1:0.
  - 3 loads bits 11:0 into `ctrl_q`.
  - 4 loads the segment-control word:
    - destination start in bits 1:0
    - destination end in bits 3:2
    - source start in bits 5:4
    - source end in bits 7:6
  - 5 is a soft reset.
  - All other opcodes are ignored.
- R5: `wr_seg` reports the destination segment counter. The counter starts at the destination start count, advances by one on each data write, and returns to the start count after a write at the end count.
- R6: `cmp_stb` pulses with the data write whose segment equals the destination end count, but only when the destination is 0 (comparand), 1 or 2 (masks). It never pulses for destination 3 (memory).
- R7: Loading the control word (opcode 3) updates `ctrl_q` and pulses `cmp_stb` in the same clock as the update.
- R8: A soft reset (opcode 5) clears `ctrl_q` and both selects. It restores the segment-control word to start 0 and end 3 for both counters, resets both counters, and gives no `cmp_stb`.
- R9: The source counter (`rd_seg`) counts from the source start count to the source end count and wraps in the same way. It changes only on data reads and is independent of the destination counter.
- R10: While `rst_n` is low, and after it, no strobe or output enable is active, `ctrl_q` is zero, the destination and source are 0, and both counters sit at 0 with an end count of 3.
- R11: A cycle acts exactly once, however long the enable stays low.
- R12: Setting the destination or the source resets that counter to its start count. Loading the segment-control word resets both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_n | input | 1 | Active-low cycle enable; a cycle starts when it falls |
| w_n | input | 1 | Active-low write select, latched at the fall |
| cm_n | input | 1 | Active-low command select, latched at the fall |
| dq_in | input | DW | Bus value driven by the host |
| dq_out | output | DW | Bus value returned to the host |
| dq_oe | output | 1 | Bus drive enable during read cycles |
| rd_data | input | DW | Slice returned by the register file for `rd_sel`/`rd_seg` |
| match_in | input | 1 | Match flag for the status word |
| full_in | input | 1 | Full flag for the status word |
| wr_stb | output | 1 | Register slice write strobe |
| wr_sel | output | 2 | Destination register of the write |
| wr_seg | output | SEGW | Segment index of the write |
| wr_data | output | DW | Slice to be written |
| rd_stb | output | 1 | Register slice read strobe |
| rd_sel | output | 2 | Source register of the read |
| rd_seg | output | SEGW | Segment index of the read |
| cmp_stb | output | 1 | Compare request |
| ctrl_q | output | 12 | Control word |

## Verification
The bench builds the block with its defaults: DW=16 and SEGW=2, which gives four segments per wide value. With two-bit counts, every start/end pair can be loaded. The bench covers a two-segment destination window starting at 1, a two-segment source window starting at 0, and the restored full window of four. These bring wrap-around, compare on the last segment, and the difference between masked and memory destinations within a few dozen cycles.

// File: rtl/host_seg_ctrl.sv
module host_seg_ctrl #(
  parameter int DW   = 16,
  parameter int SEGW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_n,
  input  logic            w_n,
  input  logic            cm_n,
  input  logic [DW-1:0]   dq_in,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   rd_data,
  input  logic            match_in,
  input  logic            full_in,
  output logic            wr_stb,
  output logic [1:0]      wr_sel,
  output logic [SEGW-1:0] wr_seg,
  output logic [DW-1:0]   wr_data,
  output logic            rd_stb,
  output logic [1:0]      rd_sel,
  output logic [SEGW-1:0] rd_seg,
  output logic            cmp_stb,
  output logic [11:0]     ctrl_q
);
  localparam logic [SEGW-1:0] SEG_LAST = {SEGW{1'b1}};
  localparam logic [1:0]      SEL_MEM  = 2'd3;

  logic            en_q, act, fall;
  logic [1:0]      typ;
  logic [1:0]      dst_sel, src_sel;
  logic [SEGW-1:0] dst_seg, src_seg;
  logic [SEGW-1:0] dst_start, dst_end, src_start, src_end;
  logic [3:0]      op;

  assign fall = en_q & ~en_n;
  assign op   = dq_in[15:12];

  function automatic logic [SEGW-1:0] seg_next(input logic [SEGW-1:0] s,
                                               input logic [SEGW-1:0] st,
                                               input logic [SEGW-1:0] en);
    return (s == en) ? st : s + 1'b1;
  endfunction

  assign dq_oe  = act & typ[1] & ~en_n;
  assign dq_out = typ[0] ? rd_data : {{(DW-2){1'b0}}, full_in, match_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b1;
      act       <= 1'b0;
      typ       <= 2'b11;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      cmp_stb   <= 1'b0;
      wr_sel    <= '0;
      wr_seg    <= '0;
      wr_data   <= '0;
      rd_sel    <= '0;
      rd_seg    <= '0;
      dst_sel   <= '0;
      src_sel   <= '0;
      dst_seg   <= '0;
      src_seg   <= '0;
      dst_start <= '0;
      dst_end   <= SEG_LAST;
      src_start <= '0;
      src_end   <= SEG_LAST;
      ctrl_q    <= '0;
    end else begin
      en_q    <= en_n;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      cmp_stb <= 1'b0;
      if (en_n) act <= 1'b0;
      if (fall) begin
        act <= 1'b1;
        typ <= {w_n, cm_n};
        case ({w_n, cm_n})
          2'b01: begin
            wr_stb  <= 1'b1;
            wr_sel  <= dst_sel;
            wr_seg  <= dst_seg;
            wr_data <= dq_in;
            dst_seg <= seg_next(dst_seg, dst_start, dst_end);
            if (dst_seg == dst_end && dst_sel != SEL_MEM) cmp_stb <= 1'b1;
          end
          2'b11: begin
            rd_stb  <= 1'b1;
            rd_sel  <= src_sel;
            rd_seg  <= src_seg;
            src_seg <= seg_next(src_seg, src_start, src_end);
          end
          2'b00: begin
            case (op)
              4'd1: begin
                dst_sel <= dq_in[1:0];
                dst_seg <= dst_start;
              end
              4'd2: begin
                src_sel <= dq_in[1:0];
                src_seg <= src_start;
              end
              4'd3: begin
                ctrl_q  <= dq_in[11:0];
                cmp_stb <= 1'b1;
              end
              4'd4: begin
                dst_start <= dq_in[SEGW-1:0];
                dst_end   <= dq_in[2*SEGW-1:SEGW];
                src_start <= dq_in[3*SEGW-1:2*SEGW];
                src_end   <= dq_in[4*SEGW-1:3*SEGW];
                dst_seg   <= dq_in[SEGW-1:0];
                src_seg   <= dq_in[3*SEGW-1:2*SEGW];
              end
              4'd5: begin
                ctrl_q    <= '0;
                dst_sel   <= '0;
                src_sel   <= '0;
                dst_start <= '0;
                dst_end   <= SEG_LAST;
                src_start <= '0;
                src_end   <= SEG_LAST;
                dst_seg   <= '0;
                src_seg   <= '0;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/host_seg_ctrl_chk.sv
module host_seg_ctrl_chk #(
  parameter int SEGW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_n,
  input logic            dq_oe,
  input logic            wr_stb,
  input logic            rd_stb,
  input logic            cmp_stb,
  input logic [1:0]      wr_sel,
  input logic [SEGW-1:0] wr_seg,
  input logic [SEGW-1:0] dst_end
);
  AST_OE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !en_n); // R2
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R1
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R11
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R11
  AST_MEM_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == 2'd3) |-> !cmp_stb); // R6
  AST_CMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmp_stb) |-> wr_seg == dst_end); // R5
endmodule

bind host_seg_ctrl host_seg_ctrl_chk #(.SEGW(SEGW)) u_chk (.*);

// File: tb/host_seg_ctrl_test.sv
module host_seg_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_n = 1'b1, w_n = 1'b1, cm_n = 1'b1;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, wr_data;
  logic [15:0] rd_data;
  logic        dq_oe, wr_stb, rd_stb, cmp_stb;
  logic        match_in = 1'b1, full_in = 1'b0;
  logic [1:0]  wr_sel, rd_sel, wr_seg, rd_seg;
  logic [11:0] ctrl_q;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  assign rd_data = 16'hA000 | {12'h0, rd_sel, rd_seg};

  host_seg_ctrl uut (.*);

  // {typ[1:0], din[15:0], {wr,rd,cmp}[2:0], seg[1:0], oe, dq[15:0]}
  localparam int NV = 23;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {2'b00, 16'h4049, 3'b000, 2'd0, 1'b0, 16'h0000}, // R4 R12 segctl d1..2 s0..1
    {2'b01, 16'h1111, 3'b100, 2'd1, 1'b0, 16'h1111}, // R1 R5
    {2'b01, 16'h2222, 3'b101, 2'd2, 1'b0, 16'h2222}, // R6 end
    {2'b01, 16'h3333, 3'b100, 2'd1, 1'b0, 16'h3333}, // R5 wrap
    {2'b11, 16'h0000, 3'b010, 2'd0, 1'b1, 16'hA000}, // R2 R9
    {2'b11, 16'h0000, 3'b010, 2'd1, 1'b1, 16'hA001}, // R9
    {2'b11, 16'h0000, 3'b010, 2'd0, 1'b1, 16'hA000}, // R9 wrap
    {2'b01, 16'h4444, 3'b101, 2'd2, 1'b0, 16'h4444}, // R9 dst untouched
    {2'b10, 16'h0000, 3'b000, 2'd0, 1'b1, 16'h0001}, // R3
    {2'b00, 16'h1003, 3'b000, 2'd0, 1'b0, 16'h0000}, // R4 dest=mem
    {2'b01, 16'h5555, 3'b100, 2'd1, 1'b0, 16'h5555}, // R12
    {2'b01, 16'h6666, 3'b100, 2'd2, 1'b0, 16'h6666}, // R6 mem no cmp
    {2'b00, 16'h3ABC, 3'b001, 2'd0, 1'b0, 16'h0000}, // R7
    {2'b00, 16'h2002, 3'b000, 2'd0, 1'b0, 16'h0000}, // R4 src=2
    {2'b11, 16'h0000, 3'b010, 2'd0, 1'b1, 16'hA008}, // R12
    {2'b00, 16'h5000, 3'b000, 2'd0, 1'b0, 16'h0000}, // R8
    {2'b01, 16'h7777, 3'b100, 2'd0, 1'b0, 16'h7777}, // R8 defaults
    {2'b01, 16'h8888, 3'b100, 2'd1, 1'b0, 16'h8888},
    {2'b01, 16'h9999, 3'b100, 2'd2, 1'b0, 16'h9999},
    {2'b01, 16'hAAAA, 3'b101, 2'd3, 1'b0, 16'hAAAA}, // R6
    {2'b00, 16'hF123, 3'b000, 2'd0, 1'b0, 16'h0000}, // R4 ignored op
    {2'b01, 16'hBBBB, 3'b100, 2'd0, 1'b0, 16'hBBBB}, // R4 counter kept
    {2'b11, 16'h0000, 3'b010, 2'd0, 1'b1, 16'hA000}  // R8 src=0
  };

  logic [2:0]  got_st;
  logic [1:0]  got_seg;
  logic        got_oe;
  logic [15:0] got_dq;

  task automatic cyc(input logic [1:0] t, input logic [15:0] d, input int hold);
    @(negedge clk);
    en_n = 1'b0; w_n = t[1]; cm_n = t[0]; dq_in = d;
    @(posedge clk); #2;
    got_st  = {wr_stb, rd_stb, cmp_stb};
    got_seg = wr_stb ? wr_seg : rd_seg;
    got_dq  = t[1] ? 16'h0 : wr_data;
    @(negedge clk);
    got_oe = dq_oe;
    if (t[1]) got_dq = dq_oe ? dq_out : 16'hxxxx;
    repeat (hold) begin
      @(posedge clk); #2;
      if (wr_stb || rd_stb || cmp_stb) got_st = 3'b111;
    end
    @(negedge clk);
    en_n = 1'b1; w_n = 1'b1; cm_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset", {wr_stb, rd_stb, cmp_stb, dq_oe, ctrl_q, wr_seg, rd_seg},
        32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      cyc(v[39:38], v[37:22], 0);
      if (i == 12) chk("R7 ctrl", {20'h0, ctrl_q}, 32'h0ABC);
      if (i == 15) chk("R8 ctrl clr", {20'h0, ctrl_q}, 32'h0);
      chk($sformatf("R1-vector %0d strobes", i), {29'h0, got_st}, {29'h0, v[21:19]});
      if (v[21] || v[20])
        chk($sformatf("R5 vector %0d seg", i), {30'h0, got_seg}, {30'h0, v[18:17]});
      chk($sformatf("R2 vector %0d oe", i), {31'h0, got_oe}, {31'h0, v[16]});
      if (v[39:38] != 2'b00)
        chk($sformatf("R3 vector %0d data", i), {16'h0, got_dq}, {16'h0, v[15:0]});
    end
    // R11: long low enable gives one strobe only
    cyc(2'b01, 16'hCCCC, 4);
    chk("R11 single action", {29'h0, got_st}, {29'h0, 3'b100});
    // R3 flags follow inputs
    match_in = 1'b0; full_in = 1'b1;
    cyc(2'b10, 16'h0, 0);
    chk("R3 status", {16'h0, got_dq}, 32'h0002);
    // R10 external reset mid-run
    cyc(2'b00, 16'h3123, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R10 ctrl after reset", {20'h0, ctrl_q}, 32'h0);
    cyc(2'b01, 16'hDDDD, 0);
    chk("R10 seg after reset", {30'h0, got_seg}, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule